// File: doc/BRIEF.md
# Stack Pointer Delta Tracker

This block sits in the decode stage and follows the stack-pointer changes of push, pop, call and return operations. It keeps them in a small signed delta register instead of issuing an arithmetic micro-op for each one. The execution core holds a base stack-pointer value that stays the same across a run of stack operations. Every stack operation gets an address offset, so the memory access is formed as base plus offset by a dedicated adder. No execution-unit ALU is needed for this.

When an instruction reads the stack pointer explicitly, the block requests a synchronisation micro-op. That micro-op folds the pending delta into the base, and the delta then returns to zero. A sync is also requested when a push or pop would move the delta outside its signed range. An explicit write of the stack pointer discards the pending delta.

The delta is speculative. A checkpoint table indexed by branch tag holds a copy of it for each tag. A flush restores the delta from the entry of the mispredicted branch. The core is expected to restore its base value from the same tag.

Top module: `stack_delta_tracker`

## Requirements
- R1: After reset, spec_delta is 0, addr_valid is 0, sync_req is 0, and every checkpoint entry holds 0.
- R2: A push (op_kind 1) or call (op_kind 3) drives addr_valid=1 with addr_ofs = delta-4, and the delta becomes delta-4 on the next clock.
- R3: A pop (op_kind 2) or return (op_kind 4) drives addr_valid=1 with addr_ofs = delta, and the delta becomes delta+4 on the next clock.
- R4: A push or call that would take the delta below -128 drives sync_req=1, sync_ofs = delta, addr_ofs = -4, and the next delta is -4. A pop or return that would take the delta above 127 drives sync_req=1, sync_ofs = delta, addr_ofs = 0, and the next delta is 4.
- R5: An explicit stack-pointer read (op_kind 5) with a nonzero delta drives sync_req=1 and sync_ofs = delta, and the next delta is 0. With a zero delta it requests no sync.
- R6: An explicit stack-pointer write (op_kind 6) sets the next delta to 0 without a sync request.
- R7: When ckpt_valid=1 and there is no flush, the entry at ckpt_tag takes the delta value that results from this cycle's operation.
- R8: When flush_valid=1, the next delta is the entry at flush_tag. In that cycle the operation is ignored (addr_valid=0, sync_req=0) and so is any checkpoint write.
- R9: op_kind 0 and 7 leave the delta unchanged and drive addr_valid=0 and sync_req=0. addr_ofs and sync_ofs read 0 whenever their valid/request signal is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_kind | input | 3 | Decoded operation: 0 none, 1 push, 2 pop, 3 call, 4 return, 5 stack-pointer read, 6 stack-pointer write, 7 reserved |
| ckpt_valid | input | 1 | Save the resulting delta under ckpt_tag |
| ckpt_tag | input | 3 | Branch tag for the save |
| flush_valid | input | 1 | Restore the delta from flush_tag |
| flush_tag | input | 3 | Branch tag of the mispredicted branch |
| addr_valid | output | 1 | Current operation is a stack access |
| addr_ofs | output | 8 | Signed offset from the base for the access |
| sync_req | output | 1 | Insert a micro-op that adds sync_ofs to the base |
| sync_ofs | output | 8 | Signed delta to fold into the base |
| spec_delta | output | 8 | Current speculative delta |

## Verification
Assertions check on every cycle that the delta stays a multiple of the slot size and that a flush cycle never shows an access or a sync. They also check that non-overflowing pushes and pops step the delta by exactly one slot, and that a read sync or a write leaves a zero delta. Only the bench scenarios can show the rest. These are the exact overflow boundaries at -128 and +127, the checkpoint-then-flush restore across many later operations, and the rule that a checkpoint offered during a flush is dropped. A behavioural model compares every output on every cycle during directed and pseudo-random sequences.

// File: rtl/sdt_pkg.sv
// Package: shared operation encoding for the stack delta tracker.
// Assumes one decoded operation per cycle.
package sdt_pkg;
    typedef enum logic [2:0] {
        SK_NONE = 3'd0,
        SK_PUSH = 3'd1,
        SK_POP  = 3'd2,
        SK_CALL = 3'd3,
        SK_RET  = 3'd4,
        SK_SPRD = 3'd5,
        SK_SPWR = 3'd6,
        SK_RSVD = 3'd7
    } stk_kind_e;
endpackage

// File: rtl/sdt_step.sv
// Module: combinational next-delta and offset logic.
// It takes the current delta and one operation, and it produces the access offset,
// any sync request, and the delta after the operation.
// Assumes SLOT_BYTES is much smaller than the delta range.
module sdt_step #(
    parameter int DELTA_W    = 8,
    parameter int SLOT_BYTES = 4
) (
    input  logic signed [DELTA_W-1:0] delta_q,
    input  sdt_pkg::stk_kind_e        kind,
    output logic                      acc_vld,
    output logic signed [DELTA_W-1:0] acc_ofs,
    output logic                      sync,
    output logic signed [DELTA_W-1:0] sync_val,
    output logic signed [DELTA_W-1:0] delta_nx
);
    import sdt_pkg::*;
    localparam int MIN_D = -(2 ** (DELTA_W - 1));
    localparam int MAX_D = (2 ** (DELTA_W - 1)) - 1;

    int dv;

    // Decide offset, sync and next delta for one operation.
    always_comb begin
        dv       = int'(delta_q);
        acc_vld  = 1'b0;
        acc_ofs  = '0;
        sync     = 1'b0;
        sync_val = '0;
        delta_nx = delta_q;
        unique case (kind)
            SK_PUSH, SK_CALL: begin
                acc_vld = 1'b1;
                if (dv - SLOT_BYTES < MIN_D) begin
                    sync     = 1'b1;
                    sync_val = delta_q;
                    acc_ofs  = DELTA_W'(-SLOT_BYTES);
                    delta_nx = DELTA_W'(-SLOT_BYTES);
                end else begin
                    acc_ofs  = DELTA_W'(dv - SLOT_BYTES);
                    delta_nx = DELTA_W'(dv - SLOT_BYTES);
                end
            end
            SK_POP, SK_RET: begin
                acc_vld = 1'b1;
                if (dv + SLOT_BYTES > MAX_D) begin
                    sync     = 1'b1;
                    sync_val = delta_q;
                    acc_ofs  = '0;
                    delta_nx = DELTA_W'(SLOT_BYTES);
                end else begin
                    acc_ofs  = delta_q;
                    delta_nx = DELTA_W'(dv + SLOT_BYTES);
                end
            end
            SK_SPRD: begin
                if (delta_q != '0) begin
                    sync     = 1'b1;
                    sync_val = delta_q;
                end
                delta_nx = '0;
            end
            SK_SPWR: delta_nx = '0;
            default: delta_nx = delta_q;
        endcase
    end
endmodule

// File: rtl/sdt_ckpt_table.sv
// Module: checkpoint table of speculative delta values, one per branch tag.
// It has one write port and one asynchronous read port.
// Assumes NUM_TAGS is a power of two.
module sdt_ckpt_table #(
    parameter int DELTA_W  = 8,
    parameter int NUM_TAGS = 8,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [TAG_W-1:0]          wr_tag,
    input  logic signed [DELTA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]          rd_tag,
    output logic signed [DELTA_W-1:0] rd_data
);
    logic signed [DELTA_W-1:0] ent [NUM_TAGS];

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_ent
        // Hold one tag's saved delta.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (wr_en && wr_tag == TAG_W'(g))
                ent[g] <= wr_data;
        end
    end

    // Read the selected tag.
    assign rd_data = ent[rd_tag];
endmodule

// File: rtl/stack_delta_tracker.sv
// Module: front-end stack-pointer delta tracker (top).
// It holds the speculative delta, gives each stack operation its offset from the
// core's base, asks for sync micro-ops, and checkpoints and restores the delta by branch tag.
// Assumes the core restores its base from the same tag on a flush.
module stack_delta_tracker #(
    parameter int DELTA_W    = 8,
    parameter int SLOT_BYTES = 4,
    parameter int NUM_TAGS   = 8,
    localparam int TAG_W     = $clog2(NUM_TAGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op_kind,
    input  logic               ckpt_valid,
    input  logic [TAG_W-1:0]   ckpt_tag,
    input  logic               flush_valid,
    input  logic [TAG_W-1:0]   flush_tag,
    output logic               addr_valid,
    output logic [DELTA_W-1:0] addr_ofs,
    output logic               sync_req,
    output logic [DELTA_W-1:0] sync_ofs,
    output logic [DELTA_W-1:0] spec_delta
);
    import sdt_pkg::*;

    logic signed [DELTA_W-1:0] delta_q, delta_nx, delta_d, restore_val;
    logic signed [DELTA_W-1:0] st_ofs, st_sync_val;
    logic                      st_acc, st_sync;
    stk_kind_e                 kind;

    assign kind = stk_kind_e'(op_kind);

    sdt_step #(.DELTA_W(DELTA_W), .SLOT_BYTES(SLOT_BYTES)) i_step (
        .delta_q (delta_q),
        .kind    (kind),
        .acc_vld (st_acc),
        .acc_ofs (st_ofs),
        .sync    (st_sync),
        .sync_val(st_sync_val),
        .delta_nx(delta_nx)
    );

    sdt_ckpt_table #(.DELTA_W(DELTA_W), .NUM_TAGS(NUM_TAGS)) i_tab (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ckpt_valid && !flush_valid),
        .wr_tag (ckpt_tag),
        .wr_data(delta_nx),
        .rd_tag (flush_tag),
        .rd_data(restore_val)
    );

    // Flush wins over the operation in the same cycle.
    assign delta_d = flush_valid ? restore_val : delta_nx;

    // Speculative delta register.
    always_ff @(posedge clk) begin
        if (!rst_n) delta_q <= '0;
        else        delta_q <= delta_d;
    end

    // Output gating: a flush cycle shows no access and no sync.
    assign addr_valid = st_acc && !flush_valid;
    assign addr_ofs   = addr_valid ? st_ofs : '0;
    assign sync_req   = st_sync && !flush_valid;
    assign sync_ofs   = sync_req ? st_sync_val : '0;
    assign spec_delta = delta_q;

    // R2: the delta stays slot aligned
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(delta_q) % SLOT_BYTES) == 0);

    // R8: nothing is issued during a flush
    p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (!addr_valid && !sync_req));

    // R2: a plain push steps down by one slot
    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == SK_PUSH || kind == SK_CALL) && !flush_valid && !sync_req)
        |=> int'(delta_q) == int'($past(delta_q)) - SLOT_BYTES);

    // R3: a plain pop steps up by one slot
    p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == SK_POP || kind == SK_RET) && !flush_valid && !sync_req)
        |=> int'(delta_q) == int'($past(delta_q)) + SLOT_BYTES);

    // R5, R6: a read or write of the stack pointer clears the delta
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == SK_SPRD || kind == SK_SPWR) && !flush_valid) |=> delta_q == '0);

    // R6: a write never asks for a sync
    p_wr_nosync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SK_SPWR) |-> !sync_req);
endmodule

// File: tb/test_stack_delta_tracker.sv
module test_stack_delta_tracker;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] op_kind;
    logic       ckpt_valid, flush_valid;
    logic [2:0] ckpt_tag, flush_tag;
    logic       addr_valid, sync_req;
    logic signed [7:0] addr_ofs, sync_ofs, spec_delta;

    int n_cmp = 0, n_bad = 0, n_cyc = 0;
    bit done = 0;
    int m_delta;
    int m_ck [8];

    always #2 clk = ~clk;

    stack_delta_tracker i_stack_delta_tracker (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind),
        .ckpt_valid(ckpt_valid), .ckpt_tag(ckpt_tag),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .addr_valid(addr_valid), .addr_ofs(addr_ofs),
        .sync_req(sync_req), .sync_ofs(sync_ofs), .spec_delta(spec_delta)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One cycle: drive, compare against the model, advance the model.
    task automatic cyc(string req, int k, bit ckv = 0, int ckt = 0, bit flv = 0, int flt = 0);
        int e_av, e_ao, e_sr, e_so, nxt;
        @(negedge clk);
        op_kind = 3'(k); ckpt_valid = ckv; ckpt_tag = 3'(ckt);
        flush_valid = flv; flush_tag = 3'(flt);
        e_av = 0; e_ao = 0; e_sr = 0; e_so = 0; nxt = m_delta;
        if (flv) nxt = m_ck[flt];
        else begin
            case (k)
                1, 3: begin
                    e_av = 1;
                    if (m_delta - 4 < -128) begin e_sr = 1; e_so = m_delta; e_ao = -4; nxt = -4; end
                    else begin e_ao = m_delta - 4; nxt = m_delta - 4; end
                end
                2, 4: begin
                    e_av = 1;
                    if (m_delta + 4 > 127) begin e_sr = 1; e_so = m_delta; e_ao = 0; nxt = 4; end
                    else begin e_ao = m_delta; nxt = m_delta + 4; end
                end
                5: begin if (m_delta != 0) begin e_sr = 1; e_so = m_delta; end nxt = 0; end
                6: nxt = 0;
                default: nxt = m_delta;
            endcase
            if (ckv) m_ck[ckt] = nxt;
        end
        #1;
        chk(req, "spec_delta", int'(spec_delta), m_delta);
        chk(req, "addr_valid", int'(addr_valid), e_av);
        chk(req, "addr_ofs", int'(addr_ofs), e_ao);
        chk(req, "sync_req", int'(sync_req), e_sr);
        chk(req, "sync_ofs", int'(sync_ofs), e_so);
        @(posedge clk);
        m_delta = nxt;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", n_cyc);
            summary();
        end
    end

    initial begin
        rst_n = 0; op_kind = 0; ckpt_valid = 0; ckpt_tag = 0; flush_valid = 0; flush_tag = 0;
        m_delta = 0;
        for (int i = 0; i < 8; i++) m_ck[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state, and every entry restores to zero
        cyc("R1", 0);
        for (int i = 0; i < 8; i++) begin
            cyc("R2", 1);
            cyc("R1", 0, 0, 0, 1, i);
        end
        // R2 / R3: pushes, calls, pops, returns
        cyc("R2", 1); cyc("R2", 3); cyc("R2", 1);
        cyc("R3", 2); cyc("R3", 4); cyc("R3", 2); cyc("R3", 2);
        // R9: none and reserved codes
        cyc("R9", 0); cyc("R9", 7); cyc("R9", 7);
        // R5: read with nonzero delta, then with zero delta
        cyc("R5", 5); cyc("R5", 5);
        // R6: write clears the delta
        cyc("R2", 1); cyc("R2", 1); cyc("R6", 6); cyc("R6", 0);
        // R4: push overflow below -128
        for (int i = 0; i < 33; i++) cyc("R4", 1);
        cyc("R6", 6);
        // R4: pop overflow above 127
        for (int i = 0; i < 33; i++) cyc("R4", 2);
        cyc("R6", 6);
        // R7: checkpoint takes the post-op value, then flush restores it
        cyc("R7", 1); cyc("R7", 1, 1, 3); cyc("R7", 1); cyc("R7", 2); cyc("R7", 5);
        cyc("R8", 1, 0, 0, 1, 3); cyc("R8", 0);
        // R8: checkpoint offered during a flush is dropped
        cyc("R8", 2, 1, 5, 1, 3); cyc("R8", 0, 0, 0, 1, 5); cyc("R8", 0);
        // Pseudo-random mix
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom_range(0, 99));
            int k = int'($urandom_range(0, 7));
            if (k < 5 && r < 70) k = (r % 2) ? 1 : 2;
            cyc("R7", k, r < 15, int'($urandom_range(0, 7)), r > 94, int'($urandom_range(0, 7)));
        end
        summary();
    end
endmodule